// File: doc/BRIEF.md
# Chunk-Repaired Two-Bank Cache Data Array

This block is the data path of a cache array built to keep working at low supply voltage, where individual SRAM cells fail. Each line is split into equal chunks. A per-line defect mask records which chunks cannot be trusted. Lines are collected into repair groups, and each group borrows one spare line that sits in the opposite bank. On every access in low-power mode, the block reads the addressed line and its group's spare line in the same cycle. It then builds the result chunk by chunk: each defective position is filled from the spare line and every other position comes from the line itself. Writes are split the same way.

The defect masks and group assignments come from a boot-time scan and a grouping step that run outside this block. They are loaded through a configuration port that accepts an entry only while the array is quiet. The port also refuses any entry that would let two lines of one group claim the same spare chunk. In high-power mode every line is whole, the repair path is bypassed, and a read costs one cycle less.

Top module: `fc_repair_array`

## Requirements
- R1: After reset, rd_valid and cfg_err are low, no table entry is in use and every stored bit reads as zero.
- R2: With lp_mode low, a read issued in cycle t raises rd_valid in cycle t+1 with the last value written to that address, taken whole from the addressed line.
- R3: With lp_mode high, a read issued in cycle t raises rd_valid in cycle t+2, and rd_valid is never high without a read one or two cycles earlier.
- R4: With lp_mode high, chunk k of the result (bits [k*CHUNK_W +: CHUNK_W]) comes from the spare line when bit k of the line's defect mask is set, and from the addressed line otherwise.
- R5: With lp_mode high, a write stores the chunks at defective positions into the same positions of the spare line and the rest into the addressed line. Other chunks of the spare line are left alone, so lines sharing a spare read back their own data.
- R6: The most significant address bit selects the bank. A configuration entry with repair in use whose spare line is in the same bank as the line is refused.
- R7: A configuration entry with repair in use is refused when its defect mask ANDed with the OR of the masks already accepted for the same spare line is nonzero.
- R8: A configuration write in a cycle with req_valid high, or while a read is still in flight, is refused.
- R9: A line whose entry was never accepted with cfg_valid high is accessed directly, without repair, in both modes.
- R10: With lp_mode high, a line configured as disabled returns zero on reads and ignores writes.
- R11: cfg_err is a one-cycle pulse in the cycle after a refused configuration write. A refused write leaves the table unchanged.
- R12: With lp_mode low, defect masks, spare assignments and disabled marks have no effect on reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_mode | input | 1 | 1 = low-voltage operation with chunk repair, 0 = direct access; changed only while idle |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (4) | Line address; MSB is the bank |
| req_wdata | input | LW (32) | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | LW (32) | Repaired read result |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_line | input | AW (4) | Line whose entry is written |
| cfg_valid | input | 1 | Entry in use |
| cfg_disabled | input | 1 | Line cannot be placed in any group |
| cfg_fault | input | CHUNKS (4) | Defect mask, bit k = chunk k |
| cfg_spare | input | AW (4) | Address of the group's spare line |
| cfg_err | output | 1 | Configuration refused (pulse) |

## Verification
The bench fills each group with random defect masks that never overlap within the group. It forces one known defective chunk so that collision cases exist, and it checks every read against a behavioural store of last-written values. Reads one cycle too early or too late in either mode show up as a mismatch on rd_valid. A merge that picks the wrong source, or a write that leaves a defective chunk in the data line only, returns stale bytes. If two lines of a group overwrite each other's spare chunks, one of them reads back the other's bytes. Refused configurations (overlapping mask, same-bank spare, busy port) are followed by traffic that would corrupt a neighbouring line if the entry had been taken anyway. Disabled lines must read as zero, and switching to high-power mode must make the addressed line whole again.

// File: rtl/fc_repair_pkg.sv
package fc_repair_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } fc_op_e;

    function automatic fc_op_e decode_op(input logic valid, input logic write);
        if (!valid)
            return OP_IDLE;
        return write ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/fc_bank.sv
// One bank of line storage: synchronous read, per-chunk write enables.
module fc_bank #(
    parameter  int DEPTH   = 8,
    parameter  int CHUNKS  = 4,
    parameter  int CHUNK_W = 8,
    localparam int IW      = $clog2(DEPTH),
    localparam int LW      = CHUNKS * CHUNK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IW-1:0]     rd_idx,
    output logic [LW-1:0]     rd_data,
    input  logic [CHUNKS-1:0] wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [LW-1:0]     wr_data
);

    typedef struct packed {
        logic [DEPTH-1:0][LW-1:0] mem;
        logic [LW-1:0]            rdat;
    } bank_t;

    bank_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rd_en)
            st_d.rdat = st_q.mem[rd_idx];
        for (int k = 0; k < CHUNKS; k++) begin
            if (wr_en[k])
                st_d.mem[wr_idx][k*CHUNK_W +: CHUNK_W] = wr_data[k*CHUNK_W +: CHUNK_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_data = st_q.rdat;

endmodule

// File: rtl/fc_map_table.sv
// Per-line defect masks, spare pointers, in-use and disabled marks, plus
// per-spare occupancy used to refuse overlapping group members.
module fc_map_table #(
    parameter  int LINES  = 16,
    parameter  int CHUNKS = 4,
    localparam int AW     = $clog2(LINES),
    localparam int IW     = AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              busy,
    input  logic [AW-1:0]     cfg_line,
    input  logic              cfg_valid,
    input  logic              cfg_disabled,
    input  logic [CHUNKS-1:0] cfg_fault,
    input  logic [AW-1:0]     cfg_spare,
    output logic              cfg_err,
    input  logic [AW-1:0]     lk_line,
    output logic [CHUNKS-1:0] lk_fault,
    output logic [IW-1:0]     lk_spare_idx,
    output logic              lk_disabled
);

    typedef struct packed {
        logic [LINES-1:0]             used;
        logic [LINES-1:0]             dis;
        logic [LINES-1:0][CHUNKS-1:0] fault;
        logic [LINES-1:0][CHUNKS-1:0] occ;
        logic [LINES-1:0][IW-1:0]     spare;
        logic                         err;
    } tbl_t;

    tbl_t st_q, st_d;
    logic repairs, same_bank, overlap, refuse;

    always_comb begin
        st_d      = st_q;
        repairs   = cfg_valid && !cfg_disabled;
        same_bank = (cfg_line[AW-1] == cfg_spare[AW-1]);
        overlap   = |(st_q.occ[cfg_spare] & cfg_fault);
        refuse    = busy || (repairs && (same_bank || overlap));
        st_d.err  = cfg_we && refuse;
        if (cfg_we && !refuse) begin
            st_d.used[cfg_line]  = cfg_valid;
            st_d.dis[cfg_line]   = cfg_disabled;
            st_d.fault[cfg_line] = repairs ? cfg_fault : '0;
            st_d.spare[cfg_line] = cfg_spare[IW-1:0];
            if (repairs)
                st_d.occ[cfg_spare] = st_q.occ[cfg_spare] | cfg_fault;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cfg_err      = st_q.err;
    assign lk_disabled  = st_q.used[lk_line] && st_q.dis[lk_line];
    assign lk_fault     = (st_q.used[lk_line] && !st_q.dis[lk_line]) ? st_q.fault[lk_line] : '0;
    assign lk_spare_idx = st_q.spare[lk_line];

endmodule

// File: rtl/fc_merge.sv
// Chunk multiplexer: defective positions take the spare line's chunk.
module fc_merge #(
    parameter  int CHUNKS  = 4,
    parameter  int CHUNK_W = 8,
    localparam int LW      = CHUNKS * CHUNK_W
) (
    input  logic [LW-1:0]     home,
    input  logic [LW-1:0]     spare,
    input  logic [CHUNKS-1:0] fault,
    output logic [LW-1:0]     merged
);

    for (genvar k = 0; k < CHUNKS; k++) begin : g_chunk
        assign merged[k*CHUNK_W +: CHUNK_W] = fault[k] ? spare[k*CHUNK_W +: CHUNK_W]
                                                       : home[k*CHUNK_W +: CHUNK_W];
    end

endmodule

// File: rtl/fc_repair_array.sv
module fc_repair_array
    import fc_repair_pkg::*;
#(
    parameter  int CHUNKS  = 4,
    parameter  int CHUNK_W = 8,
    parameter  int LINES   = 16,
    localparam int AW      = $clog2(LINES),
    localparam int LW      = CHUNKS * CHUNK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [LW-1:0]     req_wdata,
    output logic              rd_valid,
    output logic [LW-1:0]     rd_data,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_line,
    input  logic              cfg_valid,
    input  logic              cfg_disabled,
    input  logic [CHUNKS-1:0] cfg_fault,
    input  logic [AW-1:0]     cfg_spare,
    output logic              cfg_err
);

    localparam int DEPTH = LINES / 2;
    localparam int IW    = AW - 1;

    typedef struct packed {
        logic              v;
        logic              lp;
        logic              bank;
        logic              dis;
        logic [CHUNKS-1:0] fault;
    } fetch_t;

    typedef struct packed {
        logic          v;
        logic [LW-1:0] data;
    } fix_t;

    typedef struct packed {
        fetch_t s1;
        fix_t   s2;
    } pipe_t;

    pipe_t p_q, p_d;

    fc_op_e            op;
    logic              req_bank;
    logic [IW-1:0]     req_idx;
    logic [CHUNKS-1:0] lk_fault;
    logic [IW-1:0]     lk_spare_idx;
    logic              lk_disabled;
    logic              busy;

    logic [1:0]             b_rd_en;
    logic [1:0][IW-1:0]     b_rd_idx;
    logic [1:0][IW-1:0]     b_wr_idx;
    logic [1:0][CHUNKS-1:0] b_wr_en;
    logic [1:0][LW-1:0]     b_rdata;
    logic [LW-1:0]          home_data, spare_data, merged;

    assign op       = decode_op(req_valid, req_write);
    assign req_bank = req_addr[AW-1];
    assign req_idx  = req_addr[IW-1:0];
    assign busy     = req_valid || p_q.s1.v || p_q.s2.v;

    fc_map_table #(.LINES(LINES), .CHUNKS(CHUNKS)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .busy         (busy),
        .cfg_line     (cfg_line),
        .cfg_valid    (cfg_valid),
        .cfg_disabled (cfg_disabled),
        .cfg_fault    (cfg_fault),
        .cfg_spare    (cfg_spare),
        .cfg_err      (cfg_err),
        .lk_line      (req_addr),
        .lk_fault     (lk_fault),
        .lk_spare_idx (lk_spare_idx),
        .lk_disabled  (lk_disabled)
    );

    // Bank steering: home bank takes the addressed index, the other bank the spare index.
    always_comb begin
        for (int g = 0; g < 2; g++) begin
            logic home;
            home        = (int'(req_bank) == g);
            b_rd_en[g]  = (op == OP_READ) && (home || lp_mode);
            b_rd_idx[g] = home ? req_idx : lk_spare_idx;
            b_wr_idx[g] = home ? req_idx : lk_spare_idx;
            b_wr_en[g]  = '0;
            if (op == OP_WRITE) begin
                if (!lp_mode)
                    b_wr_en[g] = home ? '1 : '0;
                else if (!lk_disabled)
                    b_wr_en[g] = home ? ~lk_fault : lk_fault;
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        fc_bank #(.DEPTH(DEPTH), .CHUNKS(CHUNKS), .CHUNK_W(CHUNK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (b_rd_en[g]),
            .rd_idx  (b_rd_idx[g]),
            .rd_data (b_rdata[g]),
            .wr_en   (b_wr_en[g]),
            .wr_idx  (b_wr_idx[g]),
            .wr_data (req_wdata)
        );
    end

    assign home_data  = b_rdata[p_q.s1.bank];
    assign spare_data = b_rdata[~p_q.s1.bank];

    fc_merge #(.CHUNKS(CHUNKS), .CHUNK_W(CHUNK_W)) u_merge (
        .home   (home_data),
        .spare  (spare_data),
        .fault  (p_q.s1.fault),
        .merged (merged)
    );

    always_comb begin
        p_d          = p_q;
        p_d.s1.v     = (op == OP_READ);
        p_d.s1.lp    = lp_mode;
        p_d.s1.bank  = req_bank;
        p_d.s1.dis   = lk_disabled;
        p_d.s1.fault = lk_fault;
        p_d.s2.v     = p_q.s1.v && p_q.s1.lp;
        p_d.s2.data  = p_q.s1.dis ? '0 : merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            p_q <= '0;
        else
            p_q <= p_d;
    end

    assign rd_valid = p_q.s2.v || (p_q.s1.v && !p_q.s1.lp);
    assign rd_data  = p_q.s2.v ? p_q.s2.data : home_data;

endmodule

// File: rtl/fc_repair_chk.sv
module fc_repair_chk #(
    parameter  int LINES = 16,
    localparam int AW    = $clog2(LINES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lp_mode,
    input logic          req_valid,
    input logic          req_write,
    input logic          rd_valid,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_line,
    input logic          cfg_valid,
    input logic          cfg_disabled,
    input logic [AW-1:0] cfg_spare,
    input logic          cfg_err
);

    logic rd_req;
    assign rd_req = req_valid && !req_write;

    AST_HP_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !lp_mode) |=> rd_valid); // R2

    AST_LP_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && lp_mode) |=> ##1 rd_valid); // R3

    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_req) || $past(rd_req, 2))); // R3

    AST_SAME_BANK_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_valid && !cfg_disabled && (cfg_line[AW-1] == cfg_spare[AW-1])) |=> cfg_err); // R6

    AST_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && req_valid) |=> cfg_err); // R8

    AST_ERR_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we)); // R11

endmodule

bind fc_repair_array fc_repair_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/tb_fc_repair_array.sv
`timescale 1ns/1ps
module tb_fc_repair_array;

    localparam int AW = 4;
    localparam int LW = 32;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lp_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [LW-1:0] rd_data;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_line = '0;
    logic          cfg_valid = 1'b0;
    logic          cfg_disabled = 1'b0;
    logic [3:0]    cfg_fault = '0;
    logic [AW-1:0] cfg_spare = '0;
    logic          cfg_err;

    fc_repair_array dut (.*);

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R2";

    // behavioural reference: last written value per line, disabled marks, read history
    logic [LW-1:0] mdl [NL];
    bit            mdis [NL];
    logic [3:0]    flt [NL];
    bit            hv0, hv1;
    logic [LW-1:0] hd0, hd1;

    task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        bit            isrd;
        bit            expv;
        logic [LW-1:0] e, expd;
        isrd = req_valid && !req_write;
        e    = (lp_mode && mdis[req_addr]) ? '0 : mdl[req_addr];
        if (req_valid && req_write && !(lp_mode && mdis[req_addr]))
            mdl[req_addr] = req_wdata;
        @(posedge clk);
        @(negedge clk);
        hv1 = hv0; hd1 = hd0; hv0 = isrd; hd0 = e;
        expv = lp_mode ? hv1 : hv0;
        expd = lp_mode ? hd1 : hd0;
        chk(rd_valid == expv, lp_mode ? "R3 rd_valid timing" : "R2 rd_valid timing",
            LW'(rd_valid), LW'(expv));
        if (expv && rd_valid)
            chk(rd_data == expd, cur_tag, rd_data, expd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input int a, input logic [LW-1:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        step();
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        step();
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        req_valid = 1'b0; cfg_we = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NL; i++) begin mdl[i] = '0; mdis[i] = 1'b0; end
        hv0 = 1'b0; hv1 = 1'b0; hd0 = '0; hd1 = '0;
    endtask

    task automatic do_cfg(input int line, input bit v, input bit d, input logic [3:0] f,
                          input int spare, input bit with_read, input int rd_line,
                          input bit exp_err, input string tag);
        cfg_we = 1'b1; cfg_line = AW'(line); cfg_valid = v; cfg_disabled = d;
        cfg_fault = f; cfg_spare = AW'(spare);
        if (with_read) begin
            req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(rd_line);
        end
        step();
        cfg_we = 1'b0; req_valid = 1'b0;
        chk(cfg_err == exp_err, tag, LW'(cfg_err), LW'(exp_err));
        if (!exp_err && v && d) mdis[line] = 1'b1;
        step();
        chk(cfg_err == 1'b0, "R11 cfg_err pulse length", LW'(cfg_err), 0);
    endtask

    // groups: {0,1,2,3}->spare 8, {4,5}->spare 9, {10,11,12}->spare 6
    int g0 [4] = '{0, 1, 2, 3};
    int g1 [2] = '{4, 5};
    int g2 [3] = '{10, 11, 12};
    int traffic [13] = '{0, 1, 2, 3, 4, 5, 7, 10, 11, 12, 13, 14, 15};

    task automatic build_faults();
        int owner;
        for (int i = 0; i < NL; i++) flt[i] = '0;
        for (int k = 0; k < 4; k++) begin
            owner = (k == 0) ? 0 : $urandom_range(0, 4);
            if (owner < 4) flt[g0[owner]][k] = 1'b1;
            owner = $urandom_range(0, 2);
            if (owner < 2) flt[g1[owner]][k] = 1'b1;
            owner = $urandom_range(0, 3);
            if (owner < 3) flt[g2[owner]][k] = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: quiet outputs and zeroed storage after reset
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", LW'(rd_valid), 0);
        chk(cfg_err == 1'b0, "R1 cfg_err after reset", LW'(cfg_err), 0);
        cur_tag = "R1 stored data zero";
        rd(5); rd(12); idle(2);

        // R2: high-power direct access, one-cycle reads, back-to-back
        cur_tag = "R2 direct read";
        for (int i = 0; i < NL; i++) wr(i, $urandom());
        for (int i = 0; i < NL; i++) rd(i);
        rd(3); wr(3, 32'hA5A5_5A5A); rd(3);
        idle(2);

        // low-power phase with random, per-group collision-free masks
        do_reset();
        lp_mode = 1'b1;
        idle(2);
        build_faults();
        for (int i = 0; i < 4; i++) do_cfg(g0[i], 1, 0, flt[g0[i]], 8, 0, 0, 0, "R7 legal member accepted");
        for (int i = 0; i < 2; i++) do_cfg(g1[i], 1, 0, flt[g1[i]], 9, 0, 0, 0, "R7 legal member accepted");
        for (int i = 0; i < 3; i++) do_cfg(g2[i], 1, 0, flt[g2[i]], 6, 0, 0, 0, "R7 legal member accepted");
        do_cfg(13, 1, 1, 4'b0000, 0, 0, 0, 0, "R10 disabled entry accepted");

        // R4: repaired reads, including back-to-back
        cur_tag = "R4 repaired read";
        for (int i = 0; i < 13; i++) wr(traffic[i], $urandom());
        for (int i = 0; i < 13; i++) rd(traffic[i]);
        idle(2);

        // R5: group neighbours write into disjoint spare chunks
        cur_tag = "R5 split write";
        wr(1, 32'h1111_1111); wr(0, 32'h0000_00F0); wr(2, 32'h2222_2222); wr(3, 32'h3333_3333);
        rd(1); rd(0); rd(2); rd(3);
        wr(11, 32'hBEEF_CAFE); wr(10, 32'h0BAD_F00D); rd(11); rd(10); rd(12);
        idle(2);

        // R7: overlap with group 0 (line 0 always owns chunk 0 of spare 8)
        do_cfg(7, 1, 0, 4'b0001, 8, 0, 0, 1, "R7 overlapping mask refused");
        cur_tag = "R7 refused entry has no effect";
        wr(7, 32'h7777_7777); rd(0); rd(7);
        idle(2);

        // R6: spare in the same bank
        do_cfg(14, 1, 0, 4'b0001, 15, 0, 0, 1, "R6 same-bank spare refused");
        cur_tag = "R6 refused entry has no effect";
        wr(15, 32'h1515_1515); wr(14, 32'h1414_1414); rd(15); rd(14);
        idle(2);

        // R8: busy in the same cycle, then with a read in flight
        do_cfg(7, 1, 0, 4'b0010, 14, 1, 2, 1, "R8 cfg with request refused");
        rd(4);
        do_cfg(7, 1, 0, 4'b0100, 14, 0, 0, 1, "R8 cfg with read in flight refused");
        cur_tag = "R8 refused entry has no effect";
        wr(14, 32'h0E0E_0E0E); wr(7, 32'hFFFF_FFFF); rd(14); rd(7);
        idle(2);

        // R9: never-configured lines
        cur_tag = "R9 unconfigured direct";
        wr(15, 32'hC0DE_0015); rd(15); wr(7, 32'h0000_0007); rd(7);
        idle(2);

        // R10: disabled line
        cur_tag = "R10 disabled line";
        wr(13, 32'hDEAD_BEEF); rd(13);
        idle(2);

        // mixed random traffic, read-after-write always current
        cur_tag = "R4 random traffic";
        for (int i = 0; i < 400; i++) begin
            int a;
            a = traffic[$urandom_range(0, 12)];
            case ($urandom_range(0, 3))
                0: wr(a, $urandom());
                1, 2: rd(a);
                default: idle(1);
            endcase
        end
        idle(3);

        // R12: high-power mode ignores map and disabled marks
        lp_mode = 1'b0;
        idle(2);
        cur_tag = "R12 map ignored";
        wr(0, 32'hAAAA_0000); wr(8, 32'h5555_FFFF); rd(0); rd(8);
        wr(13, 32'h1313_1313); rd(13);
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule